// File: doc/BRIEF.md
# Address-Pattern Memory Self-Test Engine

This block is a hardware test sequencer wrapped around its own byte-wide synchronous RAM of 8 KB. The RAM sits in a 16-bit address space and answers only when the top three address bits select its region. The lower thirteen bits pick one of the bytes. A start pulse begins a test run. The engine first fills a fixed window of addresses with a pattern derived from each address. Only after that fill is complete does it read the whole window back. It compares every byte with the recomputed pattern and stops at the first byte that differs.

When the run ends the engine raises `done` together with a pass/fail verdict and, on failure, the full 16-bit address of the byte that mismatched. The RAM has one registered read port, so read data arrives one cycle after the address. A one-stage compare pipeline therefore carries each address alongside its request, and every returned byte is judged against the address that fetched it. A separate corruption port lets a testbench overwrite a single stored byte by its 13-bit index at any time, so that a failing run can be produced on purpose.

Control and status are plain levels and pulses. The block has no streaming interface and so no back-pressure: `start` is sampled on every clock edge, and it is taken only while the engine is not `busy`.

Top module: `mem_selftest`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy`, `done` and `pass` are 0 and `fail_addr` is 0x0000.
- R2: A `start` sampled high while `busy` is 0 begins a run. After that edge, `busy` is 1 and `done`, `pass` and `fail_addr` are all cleared to 0.
- R3: The fill pass writes the byte (address[15:8] XOR address[7:0]) to every address from 0xC000 to 0xDF7F, one address per cycle in ascending order. It takes 8064 cycles and finishes before any read is issued.
- R4: If every byte in the window matches, `done` rises 16129 clock edges after the edge that accepted `start`, with `pass`=1 and `fail_addr`=0x0000.
- R5: At the first mismatching address A, the run ends with `done`=1, `pass`=0 and `fail_addr`=A, which is the failing byte's own address. `done` rises 8066+(A-0xC000) edges after the accepting edge.
- R6: When several bytes in the window are corrupted, the lowest corrupted address is the one reported.
- R7: A `start` sampled while `busy` is 1 is ignored: the run continues and its completion time does not change.
- R8: After a run, `done`, `pass` and `fail_addr` hold their values until the next accepted `start`.
- R9: The RAM responds only to addresses whose bits 15:13 equal 3'b110, and it indexes its bytes with bits 12:0. Its read data is registered and is refreshed on every selected access, writes included, with the byte held before that access.
- R10: With `cor_en` high on a clock edge, the byte at index `cor_idx` becomes `cor_data`. Corruption that writes the value a byte already holds causes no failure.
- R11: Addresses 0xDF80 to 0xDFFF (indices 0x1F80 to 0x1FFF) are neither written nor checked, so corrupting them leaves the result at pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that begins a run while idle |
| cor_en | input | 1 | Test-only: overwrite one stored byte this cycle |
| cor_idx | input | 13 | Test-only: RAM index to overwrite |
| cor_data | input | 8 | Test-only: byte value written |
| busy | output | 1 | High during the fill and check passes |
| done | output | 1 | High once a run has finished, until the next start |
| pass | output | 1 | Verdict, valid while `done` is high |
| fail_addr | output | 16 | Address of the first mismatching byte, 0 on pass |

## Verification
On every cycle the assertions check that `busy` and `done` are never high together, that `pass` appears only with `done`, and that results hold while idle. They also check that fill writes stay inside the window, that the compare stage steps one address at a time, and that an unselected RAM access leaves read data unchanged. Only the bench scenarios can show that the fill really finishes before read-back and that the reported address is the failing byte itself rather than the advanced pointer. The bench measures exact completion latencies against injected corruptions at the first, last, middle and out-of-window positions, and checks that the lowest of two faults wins.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_CHECK = 2'd2,
    ST_END   = 2'd3
  } mt_state_e;

  // Expected byte for a location: high address byte XOR low address byte.
  function automatic logic [7:0] addr_pattern(input logic [15:0] a);
    return a[15:8] ^ a[7:0];
  endfunction

endpackage

// File: rtl/mt_byte_ram.sv
module mt_byte_ram #(
  parameter int          AW    = 16,
  parameter int          IDX_W = 13,
  parameter logic [AW-IDX_W-1:0] TAG = 3'b110
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             cor_en,
  input  logic [IDX_W-1:0] cor_idx,
  input  logic [7:0]       cor_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];
  logic       hit;
  logic [IDX_W-1:0] idx;

  assign hit = en && (addr[AW-1:IDX_W] == TAG);
  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (hit) begin
      if (we) mem[idx] <= wdata;
      rdata <= mem[idx];
    end
    if (cor_en) mem[cor_idx] <= cor_data;
  end

  // R9
  miss_keeps_rdata_chk: assert property (@(posedge clk)
    (en && (addr[AW-1:IDX_W] != TAG)) |=> $stable(rdata));

endmodule

// File: rtl/mt_sequencer.sv
module mt_sequencer
  import mtest_pkg::*;
#(
  parameter logic [15:0] WIN_START = 16'hC000,
  parameter logic [15:0] WIN_END   = 16'hDF80
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        finish,
  output logic        busy,
  output logic        accept,
  output logic        ram_en,
  output logic        ram_we,
  output logic [15:0] ram_addr,
  output logic [7:0]  ram_wdata,
  output logic        issue
);
  localparam logic [15:0] WIN_LAST = WIN_END - 16'd1;

  mt_state_e   state;
  logic [15:0] ptr;

  assign busy      = (state == ST_FILL) || (state == ST_CHECK);
  assign accept    = start && !busy;
  assign issue     = (state == ST_CHECK) && (ptr != WIN_END) && !finish;
  assign ram_we    = (state == ST_FILL);
  assign ram_en    = ram_we || issue;
  assign ram_addr  = ptr;
  assign ram_wdata = addr_pattern(ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ptr   <= WIN_START;
    end else begin
      unique case (state)
        ST_IDLE, ST_END: begin
          if (accept) begin
            state <= ST_FILL;
            ptr   <= WIN_START;
          end
        end
        ST_FILL: begin
          if (ptr == WIN_LAST) begin
            state <= ST_CHECK;
            ptr   <= WIN_START;
          end else begin
            ptr <= ptr + 16'd1;
          end
        end
        ST_CHECK: begin
          if (finish)     state <= ST_END;
          else if (issue) ptr   <= ptr + 16'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  fill_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr >= WIN_START && ram_addr < WIN_END));

  // R3
  fill_ascends_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && ram_addr != WIN_LAST) |=> (ram_we && ram_addr == $past(ram_addr) + 16'd1));

endmodule

// File: rtl/mt_compare.sv
module mt_compare
  import mtest_pkg::*;
#(
  parameter logic [15:0] WIN_END = 16'hDF80
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        issue,
  input  logic [15:0] issue_addr,
  input  logic [7:0]  rdata,
  output logic        finish,
  output logic        done,
  output logic        pass,
  output logic [15:0] fail_addr
);
  localparam logic [15:0] WIN_LAST = WIN_END - 16'd1;

  logic        chk_valid;
  logic [15:0] chk_addr;
  logic        mismatch;
  logic        at_last;

  assign mismatch = chk_valid && (rdata != addr_pattern(chk_addr));
  assign at_last  = chk_valid && (chk_addr == WIN_LAST);
  assign finish   = (mismatch || at_last) && !done;

  // Address travels one stage alongside the registered read.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      chk_valid <= 1'b0;
      chk_addr  <= '0;
    end else begin
      chk_valid <= issue;
      chk_addr  <= issue_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_addr <= '0;
    end else if (finish) begin
      done      <= 1'b1;
      pass      <= !mismatch;
      fail_addr <= mismatch ? chk_addr : 16'h0000;
    end
  end

  // R5
  chk_step_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && $past(chk_valid) && !$past(clear)) |-> (chk_addr == $past(chk_addr) + 16'd1));

  // R4
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !clear) |=> (done && $stable(pass) && $stable(fail_addr)));

endmodule

// File: rtl/mem_selftest.sv
module mem_selftest
  import mtest_pkg::*;
#(
  parameter int          IDX_W     = 13,
  parameter logic [2:0]  REGION    = 3'b110,
  parameter logic [15:0] WIN_START = 16'hC000,
  parameter logic [15:0] WIN_END   = 16'hDF80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cor_en,
  input  logic [IDX_W-1:0] cor_idx,
  input  logic [7:0]       cor_data,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [15:0]      fail_addr
);
  logic        accept;
  logic        finish;
  logic        ram_en;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;
  logic        issue;

  mt_sequencer #(.WIN_START(WIN_START), .WIN_END(WIN_END)) u_seq (
    .clk(clk), .rst(rst), .start(start), .finish(finish),
    .busy(busy), .accept(accept), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .issue(issue)
  );

  mt_byte_ram #(.AW(16), .IDX_W(IDX_W), .TAG(REGION)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata),
    .cor_en(cor_en), .cor_idx(cor_idx), .cor_data(cor_data)
  );

  mt_compare #(.WIN_END(WIN_END)) u_cmp (
    .clk(clk), .rst(rst), .clear(accept), .issue(issue),
    .issue_addr(ram_addr), .rdata(ram_rdata), .finish(finish),
    .done(done), .pass(pass), .fail_addr(fail_addr)
  );

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R7
  busy_keeps_result_clear_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (fail_addr == 16'h0000 && !pass));

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));

endmodule

// File: tb/test_mem_selftest.sv
module test_mem_selftest;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        cor_en = 1'b0;
  logic [12:0] cor_idx = '0;
  logic [7:0]  cor_data = '0;
  logic        busy, done, pass;
  logic [15:0] fail_addr;

  localparam int N       = 16'hDF80 - 16'hC000;
  localparam int LAT_OK  = 2 * N + 1;

  mem_selftest i_mem_selftest (
    .clk(clk), .rst(rst), .start(start), .cor_en(cor_en), .cor_idx(cor_idx),
    .cor_data(cor_data), .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t0     = 0;
  logic done_q = 1'b0;

  typedef struct {
    logic        ok;
    logic [15:0] addr;
    int          lat;
    string       req;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[15:8] ^ a[7:0];
  endfunction

  always @(posedge clk) cyc++;

  // Monitor: time-stamps accepted starts and scores each completion.
  always @(negedge clk) begin
    if (start && !busy && !rst) t0 = cyc + 1;
    if (done && !done_q) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(pass == e.ok, e.req, "pass", pass, e.ok);
        chk(fail_addr == e.addr, e.req, "fail_addr", fail_addr, e.addr);
        chk((cyc - t0) == e.lat, e.req, "latency", cyc - t0, e.lat);
      end
    end
    done_q = done;
  end

  task automatic launch(input logic ok, input logic [15:0] addr, input int lat, input string req);
    exp_t e;
    e.ok = ok; e.addr = addr; e.lat = lat; e.req = req;
    q.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R2: run begins and previous result cleared
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(done == 1'b0, "R2", "done cleared", done, 0);
    chk(pass == 1'b0, "R2", "pass cleared", pass, 0);
    chk(fail_addr == 16'h0, "R2", "fail_addr cleared", fail_addr, 0);
  endtask

  task automatic corrupt(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    cor_en = 1'b1; cor_idx = a[12:0]; cor_data = v;
    @(negedge clk) cor_en = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(pass == 1'b0, "R1", "pass after reset", pass, 0);
    chk(fail_addr == 16'h0, "R1", "fail_addr after reset", fail_addr, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);

    // R4, R3, R9: clean run passes at full latency; R7: starts while busy ignored
    launch(1'b1, 16'h0000, LAT_OK, "R4");
    repeat (100) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after ignored start", busy, 1);
    repeat (9000) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R7", "still busy in read pass", busy, 1);
    wait_done();

    // R5, R3: first byte corrupted during fill, after it was written
    launch(1'b0, 16'hC000, N + 2, "R5");
    repeat (4000) @(negedge clk);
    corrupt(16'hC000, pat(16'hC000) ^ 8'h01);
    wait_done();

    // R8: result held while idle
    begin
      logic d0, p0; logic [15:0] f0;
      d0 = done; p0 = pass; f0 = fail_addr;
      repeat (50) @(negedge clk);
      chk(done == d0, "R8", "done held", done, d0);
      chk(pass == p0, "R8", "pass held", pass, p0);
      chk(fail_addr == f0, "R8", "fail_addr held", fail_addr, f0);
    end

    // R5: last window byte corrupted after fill
    launch(1'b0, 16'hDF7F, N + 2 + (16'hDF7F - 16'hC000), "R5");
    repeat (10000) @(negedge clk);
    corrupt(16'hDF7F, 8'h00);
    wait_done();

    // R6: two faults, lowest one reported
    launch(1'b0, 16'hC234, N + 2 + (16'hC234 - 16'hC000), "R6");
    repeat (4000) @(negedge clk);
    corrupt(16'hC5A0, 8'hFF);
    corrupt(16'hC234, 8'h00);
    wait_done();

    // R10: same-value corruption harmless; R11: region past window unchecked
    launch(1'b1, 16'h0000, LAT_OK, "R10");
    repeat (4000) @(negedge clk);
    corrupt(16'hC777, pat(16'hC777));
    corrupt(16'hDF80, 8'h55);
    corrupt(16'hDFFF, 8'hAA);
    wait_done();

    // R11: repeat with out-of-window fault only
    launch(1'b1, 16'h0000, LAT_OK, "R11");
    repeat (9000) @(negedge clk);
    corrupt(16'hDFC3, 8'h3C);
    wait_done();

    chk(q.size() == 0, "R4", "pending results", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule